// File: doc/BRIEF.md
# Mode-Selectable Multiply-Add-Accumulate Unit

This block is a compact arithmetic engine for signal-processing datapaths. One 8x8 multiplier takes the two bytes of the A operand. One shared adder combines that product, the B operand, the A operand or the fed-back result. A 17-bit result register sits at the end of the datapath. A 3-bit operation code picks one of eight operations on each clock cycle, and the code may change from one cycle to the next.

Four codes give combinational results: multiply, multiply-add, accumulate and add. The other four give registered results: multiply, multiply-add, multiply-accumulate and add. In the registered codes the result register loads at the rising edge and drives the outputs. Two signedness controls choose whether each multiplier byte is read as unsigned or as two's complement. A carry input feeds the adder, and a carry output reports the adder's carry out of bit 15.

Top module: `mode_mac_unit`

## Requirements
- R1: A low `rst_n` at a rising clock edge clears the 17-bit result register and the stored carry to zero. When `mode[2]` is 1 in the next cycle, `q` is 0 and `cout` is 0.
- R2: With `mode` 000, `q` equals the low 16 bits of `op_a[7:0]` times `op_a[15:8]` with `q[16]` = 0, `cout` is 0, and `cin` has no effect.
- R3: `sgn_lo` = 1 reads `op_a[7:0]` as two's complement and `sgn_hi` = 1 reads `op_a[15:8]` as two's complement. The product P is always the low 16 bits of the full product.
- R4: With `mode` 001, `q` = P + `op_b` + `cin` as a 17-bit unsigned sum, and `cout` = `q[16]`.
- R5: With `mode` 011, `q` = `op_a` + `op_b` + `cin` as a 17-bit unsigned sum, and `cout` = `q[16]`.
- R6: With `mode` 010, the adder adds the register value R and the 17-bit extension E of `op_b` plus `cin`. E[16] = `sgn_hi` & `op_b[15]`. The low 16 bits of `q` are the low 16 bits of R[15:0] + `op_b` + `cin`. `cout` is the carry out of bit 15. `q[16]` = R[16] ^ E[16] ^ `cout`. `q` and `cout` are combinational, and the register and the stored carry load them at the same edge.
- R7: At a rising edge the register and the stored carry load the sum and carry of the selected operation. Code 100 loads P + 0 + `cin`, code 101 loads P + `op_b` + `cin`, and code 111 loads `op_a` + `op_b` + `cin`. While `mode[2]` is 1, `q` and `cout` show the stored values.
- R8: With `mode` 110, the register loads R + X + `cin` using the same carry rule as R6. X is P extended to 17 bits with X[16] = (`sgn_lo` | `sgn_hi`) & P[15].
- R9: With `mode` 000, 001 or 011, the register and the stored carry keep their values. A later registered code shows those values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low clear of the result register |
| mode | input | 3 | Operation code |
| op_a | input | 16 | A operand; its two bytes feed the multiplier |
| op_b | input | 16 | B operand |
| sgn_lo | input | 1 | Read `op_a[7:0]` as signed |
| sgn_hi | input | 1 | Read `op_a[15:8]` as signed; also sign-extends `op_b` in accumulate |
| cin | input | 1 | Adder carry input |
| q | output | 17 | Result |
| cout | output | 1 | Adder carry out of bit 15 |

## Verification
The hardest case to reach from the ports is wraparound of the 17-bit feedback register. It needs many accumulate steps in a row, where the sign-extended top bit and the low-half carry together set bit 16. Operand and mode changes between those steps must not disturb the stored value. Directed runs accumulate all-ones B with sign extension, and repeat negative signed products, until bit 16 toggles and the register wraps. Random runs then mix the eight codes with occasional resets, so that held values are read back through the registered codes.

// File: rtl/mac_pkg.sv
// Package: shared operation codes and the helper that says which codes write the register.
// Assumes the 3-bit code layout below, where bit 2 marks the registered output path.
package mac_pkg;

    typedef enum logic [2:0] {
        OP_MUL   = 3'b000,
        OP_MADD  = 3'b001,
        OP_ACC   = 3'b010,
        OP_ADD   = 3'b011,
        OP_RMUL  = 3'b100,
        OP_RMADD = 3'b101,
        OP_MAC   = 3'b110,
        OP_RADD  = 3'b111
    } mac_op_e;

    // True for the codes that write the result register at the clock edge.
    function automatic logic op_loads(input mac_op_e op);
        return op[2] || (op == OP_ACC);
    endfunction

    // True for the codes whose outputs come from the register rather than the adder.
    function automatic logic op_registered(input mac_op_e op);
        return op[2];
    endfunction

endpackage

// File: rtl/mac_mult.sv
// Module: byte multiplier with separate signedness controls for each operand.
// Assumes the caller needs only the low 2*HALF_W bits of the product, plus a sign flag used to extend it.
module mac_mult #(
    parameter int HALF_W = 8
) (
    input  logic [HALF_W-1:0]   byte_lo,
    input  logic [HALF_W-1:0]   byte_hi,
    input  logic                sgn_lo,
    input  logic                sgn_hi,
    output logic [2*HALF_W-1:0] prod,
    output logic                prod_neg
);
    localparam int PROD_W = 2 * HALF_W;

    logic signed [HALF_W:0]   ext_lo;
    logic signed [HALF_W:0]   ext_hi;
    logic signed [PROD_W+1:0] full;

    // Extend each byte by one bit so that one signed multiply covers every signedness mix.
    always_comb begin
        ext_lo = {sgn_lo & byte_lo[HALF_W-1], byte_lo};
        ext_hi = {sgn_hi & byte_hi[HALF_W-1], byte_hi};
        full   = (PROD_W+2)'(ext_lo) * (PROD_W+2)'(ext_hi);
    end

    assign prod     = full[PROD_W-1:0];
    assign prod_neg = (sgn_lo | sgn_hi) & full[PROD_W-1];

endmodule

// File: rtl/mac_opsel.sv
// Module: picks the two adder operands and the effective carry input from the operation code.
// Assumes the operands are DATA_W+1 bits wide; bit DATA_W is zero except on the feedback paths.
module mac_opsel
    import mac_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  mac_op_e               op,
    input  logic [2*HALF_W-1:0]   op_a,
    input  logic [2*HALF_W-1:0]   op_b,
    input  logic [2*HALF_W-1:0]   prod,
    input  logic                  prod_neg,
    input  logic                  sgn_hi,
    input  logic [2*HALF_W:0]     fb,
    input  logic                  cin,
    output logic [2*HALF_W:0]     opnd_x,
    output logic [2*HALF_W:0]     opnd_y,
    output logic                  cin_eff
);
    localparam int DATA_W = 2 * HALF_W;
    localparam int RES_W  = DATA_W + 1;

    // Route the product, A, B or the fed-back result into the adder for each code.
    always_comb begin
        opnd_x = '0;
        opnd_y = '0;
        unique case (op)
            OP_MUL, OP_RMUL: begin
                opnd_x = {1'b0, prod};
                opnd_y = '0;
            end
            OP_MADD, OP_RMADD: begin
                opnd_x = {1'b0, prod};
                opnd_y = {1'b0, op_b};
            end
            OP_ADD, OP_RADD: begin
                opnd_x = {1'b0, op_a};
                opnd_y = {1'b0, op_b};
            end
            OP_ACC: begin
                opnd_x = fb;
                opnd_y = {sgn_hi & op_b[DATA_W-1], op_b};
            end
            OP_MAC: begin
                opnd_x = fb;
                opnd_y = {prod_neg, prod};
            end
            default: begin
                opnd_x = RES_W'(0);
                opnd_y = RES_W'(0);
            end
        endcase
    end

    // The plain combinational multiply adds no carry.
    assign cin_eff = cin & (op != OP_MUL);

endmodule

// File: rtl/mac_adder.sv
// Module: DATA_W-bit adder with a carry out and a top result bit formed from the operands' extension bits.
// Assumes the carry out is defined on the low DATA_W bits only.
module mac_adder #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W:0] opnd_x,
    input  logic [DATA_W:0] opnd_y,
    input  logic            cin,
    output logic [DATA_W:0] sum,
    output logic            carry
);
    logic [DATA_W:0] low;

    // Add the low halves with the carry in, then fold the two extension bits into the top bit.
    always_comb begin
        low   = {1'b0, opnd_x[DATA_W-1:0]} + {1'b0, opnd_y[DATA_W-1:0]} + {{DATA_W{1'b0}}, cin};
        carry = low[DATA_W];
        sum   = {opnd_x[DATA_W] ^ opnd_y[DATA_W] ^ low[DATA_W], low[DATA_W-1:0]};
    end

endmodule

// File: rtl/mac_accreg.sv
// Module: result register and stored carry with a synchronous active-low clear.
// Assumes the load enable is already decoded from the operation code.
module mac_accreg #(
    parameter int RES_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] d,
    input  logic             d_carry,
    output logic [RES_W-1:0] q,
    output logic             q_carry
);
    // Clear on reset, load on enable, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q_carry <= 1'b0;
        end else if (load) begin
            q       <= d;
            q_carry <= d_carry;
        end
    end

endmodule

// File: rtl/mode_mac_unit.sv
// Module: top of the mode-selectable multiply-add-accumulate unit.
// Assumes the code may change every cycle. Bit 2 of the code selects the registered output.
module mode_mac_unit
    import mac_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          mode,
    input  logic [2*HALF_W-1:0] op_a,
    input  logic [2*HALF_W-1:0] op_b,
    input  logic                sgn_lo,
    input  logic                sgn_hi,
    input  logic                cin,
    output logic [2*HALF_W:0]   q,
    output logic                cout
);
    localparam int DATA_W = 2 * HALF_W;
    localparam int RES_W  = DATA_W + 1;

    mac_op_e           op;
    logic [DATA_W-1:0] prod;
    logic              prod_neg;
    logic [RES_W-1:0]  opnd_x;
    logic [RES_W-1:0]  opnd_y;
    logic              cin_eff;
    logic [RES_W-1:0]  sum;
    logic              carry;
    logic [RES_W-1:0]  acc_q;
    logic              acc_c;

    assign op = mac_op_e'(mode);

    mac_mult #(.HALF_W(HALF_W)) u_mult (
        .byte_lo  (op_a[HALF_W-1:0]),
        .byte_hi  (op_a[DATA_W-1:HALF_W]),
        .sgn_lo   (sgn_lo),
        .sgn_hi   (sgn_hi),
        .prod     (prod),
        .prod_neg (prod_neg)
    );

    mac_opsel #(.HALF_W(HALF_W)) u_opsel (
        .op       (op),
        .op_a     (op_a),
        .op_b     (op_b),
        .prod     (prod),
        .prod_neg (prod_neg),
        .sgn_hi   (sgn_hi),
        .fb       (acc_q),
        .cin      (cin),
        .opnd_x   (opnd_x),
        .opnd_y   (opnd_y),
        .cin_eff  (cin_eff)
    );

    mac_adder #(.DATA_W(DATA_W)) u_adder (
        .opnd_x (opnd_x),
        .opnd_y (opnd_y),
        .cin    (cin_eff),
        .sum    (sum),
        .carry  (carry)
    );

    mac_accreg #(.RES_W(RES_W)) u_accreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (op_loads(op)),
        .d       (sum),
        .d_carry (carry),
        .q       (acc_q),
        .q_carry (acc_c)
    );

    // Registered codes show the stored result; the rest show the adder directly.
    always_comb begin
        if (op_registered(op)) begin
            q    = acc_q;
            cout = acc_c;
        end else begin
            q    = sum;
            cout = carry;
        end
    end

endmodule

// File: rtl/mac_checker.sv
// Module: temporal checks on the multiply-add-accumulate unit, attached to it by bind.
// Assumes it sees the top-level ports and the result register output.
module mac_checker #(
    parameter int HALF_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          mode,
    input logic [2*HALF_W-1:0] op_a,
    input logic [2*HALF_W-1:0] op_b,
    input logic                sgn_lo,
    input logic                sgn_hi,
    input logic                cin,
    input logic [2*HALF_W:0]   q,
    input logic                cout,
    input logic [2*HALF_W:0]   held_q
);
    localparam int DATA_W = 2 * HALF_W;
    localparam int RES_W  = DATA_W + 1;

    // R1: the cycle after a reset edge, a registered code shows zeros.
    p_rst_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && mode[2]) |-> (q == '0 && !cout));

    // R2: plain multiply never sets the top bit or the carry.
    p_mul_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b000) |-> (!cout && !q[RES_W-1]));

    // R5: combinational add gives the full 17-bit sum.
    p_add_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b011) |-> (q == ({1'b0, op_a} + {1'b0, op_b} + RES_W'(cin))));

    // R7: registered add shows last cycle's sum.
    p_radd_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == 3'b111 && mode[2])
        |-> (q == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + RES_W'($past(cin)))));

    // R7: registered unsigned multiply shows last cycle's product plus carry.
    p_rmul_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == 3'b100 && !$past(sgn_lo) && !$past(sgn_hi) && mode[2])
        |-> (q == (RES_W'($past(op_a[HALF_W-1:0])) * RES_W'($past(op_a[DATA_W-1:HALF_W]))
                   + RES_W'($past(cin)))));

    // R9: combinational codes other than accumulate leave the register untouched.
    p_hold_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[2] && mode != 3'b010) |=> $stable(held_q));

    // R4: multiply-add carry matches the top result bit.
    p_madd_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b001) |-> (cout == q[RES_W-1]));

endmodule

bind mode_mac_unit mac_checker #(.HALF_W(HALF_W)) u_mac_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .op_a   (op_a),
    .op_b   (op_b),
    .sgn_lo (sgn_lo),
    .sgn_hi (sgn_hi),
    .cin    (cin),
    .q      (q),
    .cout   (cout),
    .held_q (acc_q)
);

// File: tb/mode_mac_unit_bench.sv
// Bench: directed corner cases followed by seeded random vectors, all compared with a reference model kept in the bench.
module mode_mac_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        sgn_lo = 1'b0;
    logic        sgn_hi = 1'b0;
    logic        cin = 1'b0;
    logic [16:0] q;
    logic        cout;

    int n_vec = 0;
    int n_bad = 0;

    // Reference model state.
    logic [16:0] m_reg = '0;
    logic        m_car = 1'b0;
    logic        m_known = 1'b0;

    always #4 clk = ~clk;

    mode_mac_unit u_mode_mac_unit (
        .clk(clk), .rst_n(rst_n), .mode(mode), .op_a(op_a), .op_b(op_b),
        .sgn_lo(sgn_lo), .sgn_hi(sgn_hi), .cin(cin), .q(q), .cout(cout)
    );

    // Low 16 bits of the byte product under the signedness controls (R3).
    function automatic logic [15:0] ref_prod(input logic [15:0] a, input logic sl, input logic sh);
        int x;
        int y;
        logic [31:0] t;
        x = sl ? int'($signed(a[7:0])) : int'({24'd0, a[7:0]});
        y = sh ? int'($signed(a[15:8])) : int'({24'd0, a[15:8]});
        t = 32'(x * y);
        return t[15:0];
    endfunction

    // Sum rule: {carry, 17-bit result} with the carry taken out of bit 15.
    function automatic logic [17:0] ref_add(input logic [16:0] x, input logic [16:0] y, input logic c);
        logic [16:0] lo;
        lo = {1'b0, x[15:0]} + {1'b0, y[15:0]} + {16'd0, c};
        return {lo[16], x[16] ^ y[16] ^ lo[16], lo[15:0]};
    endfunction

    // Applies one vector: drive at the falling edge, check before the rising edge, then advance the model.
    task automatic apply(input logic [2:0] md, input logic [15:0] a, input logic [15:0] b,
                         input logic sl, input logic sh, input logic ci, input logic rn,
                         input string tag);
        logic [15:0] p;
        logic [17:0] s;
        logic [16:0] exp_q;
        logic        exp_c;
        @(negedge clk);
        mode = md; op_a = a; op_b = b; sgn_lo = sl; sgn_hi = sh; cin = ci; rst_n = rn;
        #2;
        p = ref_prod(a, sl, sh);
        unique case (md)
            3'b000: s = {1'b0, 1'b0, p};
            3'b001, 3'b101: s = ref_add({1'b0, p}, {1'b0, b}, ci);
            3'b011, 3'b111: s = ref_add({1'b0, a}, {1'b0, b}, ci);
            3'b100: s = ref_add({1'b0, p}, 17'd0, ci);
            3'b010: s = ref_add(m_reg, {sh & b[15], b}, ci);
            default: s = ref_add(m_reg, {(sl | sh) & p[15], p}, ci);
        endcase
        if (md[2]) begin
            exp_q = m_reg;
            exp_c = m_car;
        end else begin
            exp_q = s[16:0];
            exp_c = s[17];
        end
        if (m_known || !md[2]) begin
            n_vec++;
            if (q !== exp_q || cout !== exp_c) begin
                n_bad++;
                $display("FAIL %s mode=%b a=%h b=%h: q=%h cout=%b expected q=%h cout=%b",
                         tag, md, a, b, q, cout, exp_q, exp_c);
            end
        end
        if (!rn) begin
            m_reg = '0;
            m_car = 1'b0;
            m_known = 1'b1;
        end else if (md[2] || md == 3'b010) begin
            m_reg = s[16:0];
            m_car = s[17];
        end
    endtask

    function automatic string tag_of(input logic [2:0] md);
        case (md)
            3'b000: return "R2";
            3'b001: return "R4";
            3'b010: return "R6";
            3'b011: return "R5";
            3'b110: return "R8";
            default: return "R7";
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_0A17));
        // R1: reset, then a registered code reads zero.
        apply(3'b111, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
        apply(3'b111, 16'h1234, 16'h4321, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
        apply(3'b100, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
        // R2: unsigned maximum product, carry in ignored.
        apply(3'b000, 16'hFFFF, 16'h1111, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
        // R3: signed variants.
        apply(3'b000, 16'h8080, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, "R3");
        apply(3'b000, 16'h02FF, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
        apply(3'b000, 16'hFF02, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
        // R4: multiply-add with carry out.
        apply(3'b001, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1, "R4");
        // R5: add crossing bit 16.
        apply(3'b011, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
        // R7 then R9: load, hold over combinational codes, read back.
        apply(3'b111, 16'h0005, 16'h0007, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
        apply(3'b011, 16'h0001, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
        apply(3'b000, 16'h0303, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
        apply(3'b001, 16'h0303, 16'hAAAA, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
        apply(3'b101, 16'h0203, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
        apply(3'b100, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
        apply(3'b111, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
        // R6: accumulate sign-extended all-ones until the register wraps.
        apply(3'b100, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        for (int i = 0; i < 6; i++)
            apply(3'b010, 16'h0000, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b1, "R6");
        for (int i = 0; i < 4; i++)
            apply(3'b010, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1, "R6");
        // R8: repeated negative signed products.
        for (int i = 0; i < 8; i++)
            apply(3'b110, 16'h7F80, 16'h0000, 1'b1, 1'b1, 1'(i), 1'b1, "R8");
        apply(3'b110, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
        // Random mix of codes with occasional resets.
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] md;
            logic       rn;
            md = 3'($urandom_range(0, 7));
            rn = ($urandom_range(0, 99) != 0);
            apply(md, 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), rn, rn ? tag_of(md) : "R1");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule